// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block holds the chip's power mode and drives the clock-enable outputs that match it. Software on the CPU asks for one of four modes (run, wait, doze or stop). In wait, the CPU and memory clocks are gated and every peripheral keeps its clock. In doze, the CPU and memory clocks are also gated, and each peripheral keeps or loses its clock according to its own keep-running bit. In stop, every clock enable is dropped. Stop is only entered once an all-idle handshake says that no transfer is in progress.

While the chip sits in a low-power mode, the block watches the pending interrupt lines. A line wakes the chip only when all of these hold: it is pending; it is not masked at the interrupt controller; it is enabled at its source; and its 3-bit priority is strictly above both the programmable wakeup threshold and the core's current priority mask. A wakeup returns the block to run, turns every clock enable back on and gives a one-cycle wake pulse.

All clock enables come straight from flops that load on the same edge as the mode register, so the gating cells see clean, glitch-free levels.

Top module: `lpm_clkgate_ctrl`

## Requirements
- R1: After reset, and whenever the mode is run, `cpu_clk_en`, `mem_clk_en` and every bit of `per_clk_en` are 1, `cur_mode` is 0 and `wake` is 0.
- R2: In wait (`cur_mode` = 1), `cpu_clk_en` and `mem_clk_en` are 0 and every bit of `per_clk_en` is 1.
- R3: In doze (`cur_mode` = 2), `cpu_clk_en` and `mem_clk_en` are 0 and `per_clk_en[i]` equals `doze_keep[i]` as sampled at the previous clock edge (1 keeps peripheral i running).
- R4: A request (`mode_req_valid` = 1, `mode_req` 1 = wait, 2 = doze, 3 = stop) is sampled at a rising edge. `cur_mode` and the clock enables change together on that same edge; they never change between edges.
- R5: In stop (`cur_mode` = 3), every clock-enable output is 0.
- R6: After a stop request, the block stays in a pending state until `sys_idle` is 1 at a rising edge, and only then enters stop. While pending, `cur_mode` reads 0 and all clock enables stay 1.
- R7: If a qualifying interrupt is present at a rising edge while the block is in wait, doze, stop or stop-pending, that edge returns it to run with all enables at 1 and `wake` at 1 for exactly one cycle.
- R8: A line qualifies only if its priority `irq_prio[3i+2:3i]` is strictly greater than `wake_thresh` and strictly greater than `core_mask`. A priority equal to either one does not wake.
- R9: A line with `irq_ctrl_mask[i]` = 1 (masked) or `irq_src_en[i]` = 0 (disabled at its source) never wakes, whatever its priority.
- R10: Mode requests are ignored outside run, and a request of 0 (run) in run changes nothing.
- R11: A pending line at priority level 0 never wakes, even with threshold and mask both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_req_valid | input | 1 | Mode request strobe from the CPU |
| mode_req | input | 2 | Requested mode: 0 run, 1 wait, 2 doze, 3 stop |
| doze_keep | input | NUM_PERIPH | Per-peripheral keep-running-in-doze bits |
| wake_thresh | input | 3 | Programmable wakeup priority threshold |
| core_mask | input | 3 | Core's current interrupt priority mask |
| irq_pend | input | NUM_IRQ | Pending interrupt lines |
| irq_prio | input | 3*NUM_IRQ | Priority of line i at bits [3i+2:3i] |
| irq_ctrl_mask | input | NUM_IRQ | Interrupt-controller mask, 1 = masked |
| irq_src_en | input | NUM_IRQ | Enable at the originating module, 1 = enabled |
| sys_idle | input | 1 | All-idle handshake for stop entry |
| cpu_clk_en | output | 1 | CPU clock enable |
| mem_clk_en | output | 1 | Memory clock enable |
| per_clk_en | output | NUM_PERIPH | Per-peripheral clock enables |
| wake | output | 1 | One-cycle pulse when the block returns to run |
| cur_mode | output | 2 | Current mode: 0 run, 1 wait, 2 doze, 3 stop |

## Verification
Random interrupt sets are applied in wait and doze. Each set draws random pending, mask, source-enable, priority, threshold and core-mask values, so single vetoes and combined vetoes both appear. The result is compared with a bench rule that checks each priority against the larger of the threshold and the core mask. Directed cases then pin down where the rule breaks: a priority equal to the threshold, a priority equal to the core mask, a masked line, a line disabled at its source and a level-0 line. These tell a strict comparison from a non-strict one and tell each veto apart from the others. Doze is tried with alternating keep-running bits to show the per-peripheral choice. Stop is tried with the idle handshake held low for several cycles, which separates a controlled entry from an immediate one.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int PRIO_W = 3;

  typedef enum logic [2:0] {
    ST_RUN, ST_WAIT, ST_DOZE, ST_STOP_PEND, ST_STOP
  } lpm_state_e;

  localparam logic [1:0] MODE_RUN  = 2'd0;
  localparam logic [1:0] MODE_WAIT = 2'd1;
  localparam logic [1:0] MODE_DOZE = 2'd2;
  localparam logic [1:0] MODE_STOP = 2'd3;

  // True when a priority beats both the wakeup threshold and the core mask.
  function automatic logic prio_beats(input logic [PRIO_W-1:0] p,
                                      input logic [PRIO_W-1:0] thresh,
                                      input logic [PRIO_W-1:0] cmask);
    return (p != '0) && (p > thresh) && (p > cmask);
  endfunction

  // Externally visible mode; stop-pending still reads as run.
  function automatic logic [1:0] state_to_mode(input lpm_state_e s);
    case (s)
      ST_WAIT: return MODE_WAIT;
      ST_DOZE: return MODE_DOZE;
      ST_STOP: return MODE_STOP;
      default: return MODE_RUN;
    endcase
  endfunction
endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_IRQ-1:0]          irq_pend,
  input  logic [NUM_IRQ*PRIO_W-1:0]   irq_prio,
  input  logic [PRIO_W-1:0]           wake_thresh,
  input  logic [PRIO_W-1:0]           core_mask,
  input  logic [NUM_IRQ-1:0]          irq_ctrl_mask,
  input  logic [NUM_IRQ-1:0]          irq_src_en,
  output logic                        wake_hit
);
  logic [NUM_IRQ-1:0] line_ok;
  logic [NUM_IRQ-1:0] line_open;

  assign line_open = irq_pend & ~irq_ctrl_mask & irq_src_en;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign line_ok[i] = line_open[i] &
                        prio_beats(irq_prio[i*PRIO_W +: PRIO_W], wake_thresh, core_mask);

    // R11
    no_level0_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_ok[i] |-> (irq_prio[i*PRIO_W +: PRIO_W] != '0));
  end

  assign wake_hit = |line_ok;

  // R9
  masked_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hit |-> (|(irq_pend & ~irq_ctrl_mask & irq_src_en)));
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_req_valid,
  input  logic [1:0]  mode_req,
  input  logic        sys_idle,
  input  logic        wake_hit,
  output lpm_state_e  state_q,
  output lpm_state_e  state_d,
  output logic        wake_q
);
  logic in_low_power;
  logic take_wake;

  assign in_low_power = (state_q != ST_RUN);
  assign take_wake    = in_low_power && wake_hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (mode_req_valid) begin
          case (mode_req)
            MODE_WAIT: state_d = ST_WAIT;
            MODE_DOZE: state_d = ST_DOZE;
            MODE_STOP: state_d = ST_STOP_PEND;
            default:   state_d = ST_RUN;
          endcase
        end
      end
      ST_STOP_PEND: begin
        if (wake_hit)      state_d = ST_RUN;
        else if (sys_idle) state_d = ST_STOP;
      end
      default: begin
        if (wake_hit) state_d = ST_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= take_wake;
    end
  end

  // R6
  stop_waits_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP_PEND && !sys_idle && !wake_hit) |=> (state_q == ST_STOP_PEND));

  // R7
  wake_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_low_power && wake_hit) |=> (state_q == ST_RUN && wake_q));

  // R7
  wake_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |=> !wake_q);

  // R10
  req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !wake_hit) |=> (state_q == ST_WAIT));
endmodule

// File: rtl/lpm_gate_regs.sv
module lpm_gate_regs
  import lpm_pkg::*;
#(
  parameter int NUM_PERIPH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  lpm_state_e            state_d,
  input  lpm_state_e            state_q,
  input  logic [NUM_PERIPH-1:0] doze_keep,
  output logic                  cpu_en,
  output logic                  mem_en,
  output logic [NUM_PERIPH-1:0] per_en
);
  logic core_on_d;

  assign core_on_d = (state_d == ST_RUN) || (state_d == ST_STOP_PEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_en <= 1'b1;
      mem_en <= 1'b1;
    end else begin
      cpu_en <= core_on_d;
      mem_en <= core_on_d;
    end
  end

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_per
    logic per_on_d;
    always_comb begin
      unique case (state_d)
        ST_DOZE: per_on_d = doze_keep[i];
        ST_STOP: per_on_d = 1'b0;
        default: per_on_d = 1'b1;
      endcase
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) per_en[i] <= 1'b1;
      else        per_en[i] <= per_on_d;
    end
  end

  // R1
  run_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN || state_q == ST_STOP_PEND) |-> (cpu_en && mem_en && (&per_en)));

  // R2
  wait_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (!cpu_en && !mem_en && (&per_en)));

  // R3
  doze_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DOZE && $past(state_d == ST_DOZE)) |-> (!cpu_en && per_en == $past(doze_keep)));

  // R5
  stop_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |-> (!cpu_en && !mem_en && (per_en == '0)));
endmodule

// File: rtl/lpm_clkgate_ctrl.sv
module lpm_clkgate_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int NUM_IRQ    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode_req_valid,
  input  logic [1:0]                mode_req,
  input  logic [NUM_PERIPH-1:0]     doze_keep,
  input  logic [2:0]                wake_thresh,
  input  logic [2:0]                core_mask,
  input  logic [NUM_IRQ-1:0]        irq_pend,
  input  logic [NUM_IRQ*3-1:0]      irq_prio,
  input  logic [NUM_IRQ-1:0]        irq_ctrl_mask,
  input  logic [NUM_IRQ-1:0]        irq_src_en,
  input  logic                      sys_idle,
  output logic                      cpu_clk_en,
  output logic                      mem_clk_en,
  output logic [NUM_PERIPH-1:0]     per_clk_en,
  output logic                      wake,
  output logic [1:0]                cur_mode
);
  lpm_state_e state_q;
  lpm_state_e state_d;
  logic       wake_hit;

  lpm_wake_detect #(.NUM_IRQ(NUM_IRQ)) u_detect (
    .clk(clk), .rst_n(rst_n),
    .irq_pend(irq_pend), .irq_prio(irq_prio),
    .wake_thresh(wake_thresh), .core_mask(core_mask),
    .irq_ctrl_mask(irq_ctrl_mask), .irq_src_en(irq_src_en),
    .wake_hit(wake_hit)
  );

  lpm_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .mode_req_valid(mode_req_valid), .mode_req(mode_req),
    .sys_idle(sys_idle), .wake_hit(wake_hit),
    .state_q(state_q), .state_d(state_d), .wake_q(wake)
  );

  lpm_gate_regs #(.NUM_PERIPH(NUM_PERIPH)) u_gates (
    .clk(clk), .rst_n(rst_n),
    .state_d(state_d), .state_q(state_q), .doze_keep(doze_keep),
    .cpu_en(cpu_clk_en), .mem_en(mem_clk_en), .per_en(per_clk_en)
  );

  assign cur_mode = state_to_mode(state_q);

  // R4
  mode_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'd1) |-> (!cpu_clk_en && !mem_clk_en));
endmodule

// File: tb/sim_lpm_clkgate_ctrl.sv
module sim_lpm_clkgate_ctrl;
  localparam int NP = 4;
  localparam int NI = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_req_valid = 1'b0;
  logic [1:0] mode_req = '0;
  logic [NP-1:0] doze_keep = '0;
  logic [2:0] wake_thresh = '0;
  logic [2:0] core_mask = '0;
  logic [NI-1:0] irq_pend = '0;
  logic [NI*3-1:0] irq_prio = '0;
  logic [NI-1:0] irq_ctrl_mask = '0;
  logic [NI-1:0] irq_src_en = '0;
  logic sys_idle = 1'b0;
  logic cpu_clk_en, mem_clk_en, wake;
  logic [NP-1:0] per_clk_en;
  logic [1:0] cur_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lpm_clkgate_ctrl #(.NUM_PERIPH(NP), .NUM_IRQ(NI)) u0 (.*);

  // Larger of threshold and core mask: a line wakes only above it.
  function automatic bit model_wake(input logic [NI-1:0] p, input logic [NI*3-1:0] pr,
                                    input logic [2:0] th, input logic [2:0] cm,
                                    input logic [NI-1:0] msk, input logic [NI-1:0] en);
    int lim = (th > cm) ? th : cm;
    bit w = 0;
    for (int k = 0; k < NI; k++)
      if (p[k] && !msk[k] && en[k] && int'(pr[k*3 +: 3]) > lim) w = 1;
    return w;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Outputs packed: {wake, cur_mode, cpu, mem, per}
  function automatic int outs();
    return {wake, cur_mode, cpu_clk_en, mem_clk_en, per_clk_en};
  endfunction
  function automatic int pack(bit w, int m, bit c, bit mm, int p);
    return {w, m[1:0], c, mm, p[NP-1:0]};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_irq();
    irq_pend = '0; irq_prio = '0; irq_ctrl_mask = '0; irq_src_en = '0;
    wake_thresh = '0; core_mask = '0;
  endtask

  task automatic request(input logic [1:0] m);
    mode_req_valid = 1'b1; mode_req = m;
    step();
    mode_req_valid = 1'b0; mode_req = '0;
  endtask

  task automatic one_irq(input int idx, input logic [2:0] pr, input bit msk, input bit en);
    irq_pend[idx] = 1'b1;
    irq_prio[idx*3 +: 3] = pr;
    irq_ctrl_mask[idx] = msk;
    irq_src_en[idx] = en;
  endtask

  task automatic force_wake(input string req);
    clear_irq();
    one_irq(0, 3'd7, 1'b0, 1'b1);
    step();
    check(req, outs(), pack(1, 0, 1, 1, 4'hF));
    clear_irq();
    step();
    check({req, " pulse ends"}, int'(wake), 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    @(negedge clk);
    check("R1 in reset", outs(), pack(0, 0, 1, 1, 4'hF));
    rst_n = 1'b1;
    step();
    check("R1 after reset", outs(), pack(0, 0, 1, 1, 4'hF));

    request(2'd0);
    check("R10 run request in run", outs(), pack(0, 0, 1, 1, 4'hF));

    request(2'd1);
    check("R2 R4 wait entry", outs(), pack(0, 1, 0, 0, 4'hF));

    request(2'd3);
    check("R10 request ignored in wait", outs(), pack(0, 1, 0, 0, 4'hF));

    wake_thresh = 3'd4; one_irq(2, 3'd4, 1'b0, 1'b1);
    step();
    check("R8 prio equal threshold", outs(), pack(0, 1, 0, 0, 4'hF));

    clear_irq(); core_mask = 3'd5; wake_thresh = 3'd1; one_irq(3, 3'd5, 1'b0, 1'b1);
    step();
    check("R8 prio equal core mask", outs(), pack(0, 1, 0, 0, 4'hF));

    clear_irq(); one_irq(4, 3'd7, 1'b1, 1'b1);
    step();
    check("R9 masked source", outs(), pack(0, 1, 0, 0, 4'hF));

    clear_irq(); one_irq(5, 3'd7, 1'b0, 1'b0);
    step();
    check("R9 source disabled", outs(), pack(0, 1, 0, 0, 4'hF));

    clear_irq(); one_irq(6, 3'd0, 1'b0, 1'b1);
    step();
    check("R11 level 0", outs(), pack(0, 1, 0, 0, 4'hF));

    force_wake("R7 wake from wait");

    doze_keep = 4'b0101;
    request(2'd2);
    check("R3 doze entry", outs(), pack(0, 2, 0, 0, 4'b0101));
    doze_keep = 4'b1010;
    step();
    check("R3 doze follows keep bits", outs(), pack(0, 2, 0, 0, 4'b1010));
    force_wake("R7 wake from doze");

    sys_idle = 1'b0;
    request(2'd3);
    for (int k = 0; k < 5; k++) begin
      check("R6 stop pending", outs(), pack(0, 0, 1, 1, 4'hF));
      step();
    end
    sys_idle = 1'b1;
    step();
    check("R5 stop entered", outs(), pack(0, 3, 0, 0, 4'h0));
    force_wake("R7 wake from stop");

    sys_idle = 1'b0;
    request(2'd3);
    force_wake("R7 wake from stop pending");

    for (int it = 0; it < 300; it++) begin
      bit is_doze = $urandom_range(0, 1);
      bit ew;
      logic [NP-1:0] kp = NP'($urandom);
      doze_keep = kp;
      request(is_doze ? 2'd2 : 2'd1);
      irq_pend = NI'($urandom); irq_prio = (NI*3)'($urandom);
      irq_ctrl_mask = NI'($urandom); irq_src_en = NI'($urandom);
      wake_thresh = 3'($urandom); core_mask = 3'($urandom);
      ew = model_wake(irq_pend, irq_prio, wake_thresh, core_mask, irq_ctrl_mask, irq_src_en);
      step();
      if (ew) check("R7 R8 R9 random wake", outs(), pack(1, 0, 1, 1, 4'hF));
      else begin
        check("R8 R9 random no wake", outs(),
              pack(0, is_doze ? 2 : 1, 0, 0, is_doze ? int'(kp) : 4'hF));
        force_wake("R7 random release");
      end
      clear_irq();
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule